// File: doc/BRIEF.md
# Binary32 Normalise, Round and Pack Unit

This block finishes a single-precision operation. An arithmetic stage hands it an unpacked intermediate value: a sign, a signed exponent, and a 32-bit significand that carries eight extra bits below the final fraction LSB. The block turns that value into an IEEE-754 binary32 word. It normalises the significand and denormalises tiny values with sticky jamming. It then rounds with one add of a mode-dependent increment, absorbs a carry-out, and detects overflow. The inexact, underflow and overflow flags it raises are ORed with whatever flags the arithmetic stage already reported.

The exponent convention works as follows. Take a significand with bit 31 set at input exponent E and below the overflow limit. It packs with biased exponent field E+1. Before rounding, its fraction is significand bits 30:8, and bits 7:0 are guard bits. So exponent 126 with significand 0x80000000 gives 1.0.

The unit is a single stage. One result appears in the cycle after each accepted input and is held until the next one.

Top module: `nrp_pack_unit`

## Requirements
- R1: When the input exponent is 255 and either the significand is zero or any incoming flag is set, the word is {sign, 0xFF, significand[29:7]} and the flags equal the incoming flags. With exponent 255, a nonzero significand and no incoming flags, the value takes the ordinary path.
- R2: Outside R1, a zero significand packs a signed zero ({sign, 31'b0}), and the flags equal the incoming flags.
- R3: A nonzero significand is shifted left until bit 31 is set, and the exponent drops by the shift count. A normalised value at exponent E (0 ≤ E ≤ 253) packs with exponent field E+1 and fraction bits 30:8.
- R4: If the normalised exponent is negative, the significand is shifted right by its magnitude. Any bit shifted out is ORed into bit 0, and the exponent becomes 0, which gives a subnormal or zero word.
- R5: Rounding mode 00 is nearest-even. The increment is 0x80 when significand bit 8 is 1 and 0x7F when it is 0.
- R6: Mode 01 rounds toward +infinity and mode 10 toward −infinity. Each adds 0xFF when the sign points the way of rounding and 0 otherwise. Mode 11 truncates (increment 0). In the directed modes, exact values are unchanged.
- R7: If significand plus increment would carry out of bit 31, the exponent rises by 1 first. The significand is then shifted right one place with its old bit 0 kept in bit 0, and the increment is halved.
- R8: Inexact (flag bit 0) is raised when significand bits 7:0 are nonzero after any R7 adjustment. An exact value raises no inexact flag.
- R9: An exponent of 254 or more after R7 raises overflow (flag bit 2) and inexact. The word is infinity with the operand's sign when the increment is nonzero. When the increment is zero, the word is the largest finite magnitude with the operand's sign (0x7F7FFFFF).
- R10: Underflow (flag bit 1) is raised only when the value was tiny in R4 and bits lost or held below the LSB were nonzero. The rounded result must also still be tiny: exponent 0 and significand at most 0x80000000. A tiny value that rounds past the minimum normal raises no underflow.
- R11: The output flags are the incoming flags ORed with the raised bits (0 inexact, 1 underflow, 2 overflow). Higher flag bits pass through.
- R12: A result and out_valid appear on the clock edge after in_valid. Without in_valid, out_valid is low and the word and flags hold. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input value present this cycle |
| in_sign | input | 1 | Sign of the intermediate value |
| in_exp | input | EXP_W | Signed intermediate exponent |
| in_sig | input | 32 | Significand with 8 guard bits below the fraction LSB |
| in_rmode | input | 2 | Rounding mode: 00 nearest, 01 up, 10 down, 11 toward zero |
| in_flags | input | FLAG_W | Flags already raised by the producing stage |
| out_valid | output | 1 | Result present |
| out_word | output | 32 | Packed binary32 result |
| out_flags | output | FLAG_W | Incoming flags ORed with inexact, underflow, overflow |

## Verification
Rounding carry-out and the overflow test can act in the same cycle. An input at exponent 253 with an all-ones significand carries out and is pushed to 254, which becomes infinity with overflow. The neighbouring input 0xFFFFFF00 at the same exponent does not carry and packs exactly to the largest finite value. Tiny denormalisation and the underflow decision can also meet rounding in one cycle: rounding can lift a jammed subnormal to exactly the minimum normal, and with exponent −1 and several modes the bench checks that underflow is kept or dropped as R10 demands. Directed cases carry hand-computed words, and random inputs are compared with a reference function in the bench.

// File: rtl/nrp_pkg.sv
package nrp_pkg;
  localparam int SIG_W       = 32;
  localparam int GRD_W       = 8;
  localparam int FRAC_W      = 23;
  localparam int EXPF_W      = 8;
  localparam int EXP_SPECIAL = 255;
  localparam int EXP_OVF     = 254;

  localparam int FLG_INEXACT = 0;
  localparam int FLG_UNDER   = 1;
  localparam int FLG_OVER    = 2;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_UP   = 2'b01,
    RM_DOWN = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;
endpackage

// File: rtl/lead_zero_cnt.sv
module lead_zero_cnt #(
  parameter int W  = 32,
  localparam int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  d,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (d[i]) cnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/sticky_rshift.sv
module sticky_rshift #(
  parameter int W   = 32,
  localparam int SW = $clog2(W) + 1
) (
  input  logic [W-1:0]  d,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  q
);
  logic [SW:0][W-1:0] stg;
  logic [SW:0]        stk;

  assign stg[0] = d;
  assign stk[0] = 1'b0;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int         SH   = 1 << k;
    localparam logic [W-1:0] LOST = ~({W{1'b1}} << SH);
    assign stg[k+1] = amt[k] ? (stg[k] >> SH) : stg[k];
    assign stk[k+1] = stk[k] | (amt[k] & (|(stg[k] & LOST)));
  end

  assign q = stg[SW] | {{(W-1){1'b0}}, stk[SW]};
endmodule

// File: rtl/round_incr.sv
module round_incr #(
  parameter int GW = 8
) (
  input  nrp_pkg::rmode_e rmode,
  input  logic            sign,
  input  logic            lsb,
  output logic [GW-1:0]   incr
);
  import nrp_pkg::*;
  localparam logic [GW-1:0] HALF = {1'b1, {(GW-1){1'b0}}};
  localparam logic [GW-1:0] ONES = {GW{1'b1}};

  always_comb begin
    unique case (rmode)
      RM_NEAR: incr = lsb ? HALF : HALF - 1'b1;
      RM_UP:   incr = sign ? '0 : ONES;
      RM_DOWN: incr = sign ? ONES : '0;
      default: incr = '0;
    endcase
  end
endmodule

// File: rtl/nrp_pack_unit.sv
module nrp_pack_unit #(
  parameter int EXP_W  = 10,
  parameter int FLAG_W = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    in_sign,
  input  logic signed [EXP_W-1:0] in_exp,
  input  logic [31:0]             in_sig,
  input  logic [1:0]              in_rmode,
  input  logic [FLAG_W-1:0]       in_flags,
  output logic                    out_valid,
  output logic [31:0]             out_word,
  output logic [FLAG_W-1:0]       out_flags
);
  import nrp_pkg::*;
  localparam int CW  = $clog2(SIG_W) + 1;
  localparam int SHW = $clog2(SIG_W) + 1;
  localparam int EW2 = EXP_W + 2;

  // normalise
  logic [CW-1:0]         lz;
  logic [SIG_W-1:0]      sig_n;
  logic signed [EW2-1:0] e_n;
  lead_zero_cnt #(.W(SIG_W)) u_lzc (.d(in_sig), .cnt(lz));
  assign sig_n = in_sig << lz;
  assign e_n   = {{2{in_exp[EXP_W-1]}}, in_exp} - {{(EW2-CW){1'b0}}, lz};

  // tiny handling
  logic                  tiny;
  logic [EW2-1:0]        neg;
  logic [SHW-1:0]        shamt;
  logic [SIG_W-1:0]      sig_d;
  logic signed [EW2-1:0] e_t;
  logic                  uf_c;
  assign tiny  = e_n[EW2-1];
  assign neg   = -e_n;
  assign shamt = !tiny ? '0 :
                 (neg > EW2'(SIG_W)) ? SHW'(SIG_W) : neg[SHW-1:0];
  sticky_rshift #(.W(SIG_W)) u_jam (.d(sig_n), .amt(shamt), .q(sig_d));
  assign e_t  = tiny ? '0 : e_n;
  assign uf_c = tiny && (|sig_d[GRD_W-1:0]);

  // rounding
  logic [GRD_W-1:0]      inc0, inc_a;
  logic [SIG_W:0]        sum0;
  logic                  carry;
  logic [SIG_W-1:0]      sig_a, sig_r;
  logic signed [EW2-1:0] e_a;
  logic                  ix, ovf;
  round_incr #(.GW(GRD_W)) u_inc (
    .rmode(rmode_e'(in_rmode)), .sign(in_sign), .lsb(sig_d[GRD_W]), .incr(inc0)
  );
  assign sum0  = {1'b0, sig_d} + {{(SIG_W+1-GRD_W){1'b0}}, inc0};
  assign carry = sum0[SIG_W];
  assign sig_a = carry ? ({1'b0, sig_d[SIG_W-1:1]} | {{(SIG_W-1){1'b0}}, sig_d[0]}) : sig_d;
  assign inc_a = carry ? (inc0 >> 1) : inc0;
  assign e_a   = carry ? e_t + 1'b1 : e_t;
  assign ix    = |sig_a[GRD_W-1:0];
  assign sig_r = carry ? sig_a + {{(SIG_W-GRD_W){1'b0}}, inc_a} : sum0[SIG_W-1:0];
  assign ovf   = (e_a >= EW2'(EXP_OVF));

  // pack
  logic              special;
  logic [EXPF_W-1:0] e_fin;
  logic              uf;
  logic [31:0]       w_nxt;
  logic [FLAG_W-1:0] f_nxt;
  assign special = (in_exp == EXP_W'(EXP_SPECIAL)) && ((in_sig == '0) || (|in_flags));
  assign e_fin   = (sig_r[SIG_W-1:GRD_W] == '0) ? '0 : e_a[EXPF_W-1:0];
  assign uf      = uf_c && (e_fin == '0) && (sig_r <= {1'b1, {(SIG_W-1){1'b0}}});

  always_comb begin
    w_nxt = '0;
    f_nxt = in_flags;
    if (special) begin
      w_nxt = {in_sign, {EXPF_W{1'b1}}, in_sig[SIG_W-3 -: FRAC_W]};
    end else if (in_sig == '0) begin
      w_nxt = {in_sign, 31'b0};
    end else if (ovf) begin
      f_nxt[FLG_OVER]    = 1'b1;
      f_nxt[FLG_INEXACT] = 1'b1;
      if (inc_a == '0) w_nxt = {in_sign, {(EXPF_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
      else             w_nxt = {in_sign, {EXPF_W{1'b1}}, {FRAC_W{1'b0}}};
    end else begin
      if (ix) f_nxt[FLG_INEXACT] = 1'b1;
      if (uf) f_nxt[FLG_UNDER]   = 1'b1;
      w_nxt = {in_sign, 31'b0} |
              ({1'b0, e_fin, {FRAC_W{1'b0}}} + {{EXPF_W{1'b0}}, sig_r[SIG_W-1:GRD_W]});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_flags <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word  <= w_nxt;
        out_flags <= f_nxt;
      end
    end
  end
endmodule

// File: rtl/nrp_pack_unit_chk.sv
module nrp_pack_unit_chk #(
  parameter int EXP_W  = 10,
  parameter int FLAG_W = 5
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    in_sign,
  input logic signed [EXP_W-1:0] in_exp,
  input logic [31:0]             in_sig,
  input logic [FLAG_W-1:0]       in_flags,
  input logic                    out_valid,
  input logic [31:0]             out_word,
  input logic [FLAG_W-1:0]       out_flags
);
  import nrp_pkg::*;

  // R12
  valid_pipe_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_word) && $stable(out_flags)));

  // R11
  flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ((out_flags & $past(in_flags)) == $past(in_flags)));

  // R9
  ovf_form_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_flags[FLG_OVER]) |=>
      (!out_flags[FLG_OVER] || (out_flags[FLG_INEXACT] &&
        (out_word[30:23] == 8'hFF || out_word[30:0] == 31'h7F7FFFFF))));

  // R10
  uf_range_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_flags[FLG_UNDER]) |=>
      (!out_flags[FLG_UNDER] || (out_flags[FLG_INEXACT] &&
        (out_word[30:23] == 8'h00 || out_word[30:0] == 31'h00800000))));

  // R2
  zero_pack_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sig == '0 && in_exp != EXP_W'(EXP_SPECIAL)) |=>
      (out_word == {$past(in_sign), 31'b0}));
endmodule

bind nrp_pack_unit nrp_pack_unit_chk #(.EXP_W(EXP_W), .FLAG_W(FLAG_W)) u_chk (.*);

// File: tb/sim_nrp_pack_unit.sv
`timescale 1ns/1ps
module sim_nrp_pack_unit;
  localparam int EXP_W = 10;
  localparam int FLAG_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sign = 1'b0;
  logic signed [EXP_W-1:0] in_exp = '0;
  logic [31:0] in_sig = '0;
  logic [1:0]  in_rmode = '0;
  logic [FLAG_W-1:0] in_flags = '0;
  logic out_valid;
  logic [31:0] out_word;
  logic [FLAG_W-1:0] out_flags;

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nrp_pack_unit #(.EXP_W(EXP_W), .FLAG_W(FLAG_W)) u0 (.*);

  // flags: bit0 inexact, bit1 underflow, bit2 overflow
  function automatic void ref_model(input bit s, input int e, input bit [31:0] m,
      input bit [1:0] rm, input bit [4:0] fi, output bit [31:0] w, output bit [4:0] fo);
    longint unsigned v, inc, lost, tmp;
    int ex;
    bit ucand, ix, uf;
    fo = fi;
    if (e == 255 && (m == 0 || fi != 0)) begin w = {s, 8'hFF, m[29:7]}; return; end
    if (m == 0) begin w = {s, 31'd0}; return; end
    v = m; ex = e; ucand = 0;
    while (v < 64'h8000_0000) begin v = v * 2; ex--; end
    if (ex < 0) begin
      lost = 0;
      for (int i = 0; i < -ex; i++) begin lost |= v & 1; v = v >> 1; end
      v |= lost; ex = 0; ucand = (v & 255) != 0;
    end
    case (rm)
      2'b00: inc = (v & 256) ? 128 : 127;
      2'b01: inc = s ? 0 : 255;
      2'b10: inc = s ? 255 : 0;
      default: inc = 0;
    endcase
    if (v + inc > 64'hFFFF_FFFF) begin ex++; v = (v >> 1) | (v & 1); inc = inc / 2; end
    ix = (v & 255) != 0;
    v = v + inc;
    if (ex >= 254) begin
      fo |= 5'b00101;
      w = (inc == 0) ? {s, 31'h7F7FFFFF} : {s, 8'hFF, 23'd0};
      return;
    end
    if ((v >> 8) == 0) ex = 0;
    uf = ucand && ex == 0 && v <= 64'h8000_0000;
    tmp = longint'(ex) * 64'd8388608 + (v >> 8);
    w = {s, tmp[30:0]};
    if (ix) fo[0] = 1'b1;
    if (uf) fo[1] = 1'b1;
  endfunction

  task automatic check(input bit ok, input string tag, input bit [31:0] gw,
      input bit [4:0] gf, input bit [31:0] xw, input bit [4:0] xf);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual word=%h flags=%b, expected word=%h flags=%b",
               tag, gw, gf, xw, xf);
    end
  endtask

  task automatic apply(input bit s, input int e, input bit [31:0] m, input bit [1:0] rm,
      input bit [4:0] fi, input bit [31:0] xw, input bit [4:0] xf, input string tag);
    @(negedge clk);
    in_valid = 1; in_sign = s; in_exp = e[EXP_W-1:0]; in_sig = m; in_rmode = rm; in_flags = fi;
    @(negedge clk);
    in_valid = 0;
    check(out_valid && out_word == xw && out_flags == xf, tag, out_word, out_flags, xw, xf);
  endtask

  task automatic dir(input bit s, input int e, input bit [31:0] m, input bit [1:0] rm,
      input bit [4:0] fi, input bit [31:0] xw, input bit [4:0] xf, input string tag);
    bit [31:0] mw; bit [4:0] mf;
    ref_model(s, e, m, rm, fi, mw, mf);
    if (mw != xw || mf != xf) $display("note: model differs on %s", tag);
    apply(s, e, m, rm, fi, xw, xf, tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(!out_valid && out_word == 0 && out_flags == 0, "R12 reset", out_word, out_flags, 0, 0);
    rst = 0;

    dir(0, 126, 32'h80000000, 2'b00, 0, 32'h3F800000, 5'b00000, "R3 one");
    dir(0, 133, 32'h00000001, 2'b00, 0, 32'h33800000, 5'b00000, "R3 lz31");
    dir(1, 50, 32'h0, 2'b00, 5'b10000, 32'h80000000, 5'b10000, "R2 neg zero");
    dir(0, 255, 32'h0, 2'b00, 0, 32'h7F800000, 5'b00000, "R1 inf pass");
    dir(1, 255, 32'h20000080, 2'b00, 5'b01000, 32'hFFC00001, 5'b01000, "R1 nan pass");
    dir(0, 255, 32'h40000000, 2'b00, 0, 32'h7F800000, 5'b00101, "R1 no-pass path");
    dir(0, 126, 32'h80000180, 2'b00, 0, 32'h3F800002, 5'b00001, "R5 tie odd up");
    dir(0, 126, 32'h80000080, 2'b00, 0, 32'h3F800000, 5'b00001, "R5 tie even down");
    dir(0, 126, 32'h800000C0, 2'b00, 0, 32'h3F800001, 5'b00001, "R5 above half");
    dir(0, 126, 32'h80000001, 2'b01, 0, 32'h3F800001, 5'b00001, "R6 up pos");
    dir(1, 126, 32'h80000001, 2'b01, 0, 32'hBF800000, 5'b00001, "R6 up neg");
    dir(1, 126, 32'h80000001, 2'b10, 0, 32'hBF800001, 5'b00001, "R6 down neg");
    dir(0, 126, 32'h80000001, 2'b10, 0, 32'h3F800000, 5'b00001, "R6 down pos");
    dir(0, 126, 32'h80000001, 2'b11, 0, 32'h3F800000, 5'b00001, "R6 zero");
    dir(0, 126, 32'hFFFFFFC0, 2'b00, 0, 32'h40000000, 5'b00001, "R7 carry near");
    dir(0, 126, 32'hFFFFFF01, 2'b01, 0, 32'h40000000, 5'b00001, "R7 carry up");
    dir(0, 126, 32'hC0000000, 2'b01, 0, 32'h3FC00000, 5'b00000, "R8 exact up");
    dir(0, 126, 32'hC0000000, 2'b00, 5'b00001, 32'h3FC00000, 5'b00001, "R11 inexact kept");
    dir(0, 253, 32'hFFFFFFFF, 2'b00, 0, 32'h7F800000, 5'b00101, "R9 carry to inf");
    dir(0, 253, 32'hFFFFFF00, 2'b00, 0, 32'h7F7FFFFF, 5'b00000, "R9 max exact");
    dir(0, 254, 32'h80000000, 2'b11, 0, 32'h7F7FFFFF, 5'b00101, "R9 sat zero");
    dir(0, 254, 32'h80000000, 2'b10, 0, 32'h7F7FFFFF, 5'b00101, "R9 sat down");
    dir(1, 254, 32'h80000000, 2'b10, 0, 32'hFF800000, 5'b00101, "R9 neg inf");
    dir(1, 300, 32'h80000000, 2'b01, 0, 32'hFF7FFFFF, 5'b00101, "R9 neg sat");
    dir(0, 254, 32'h80000000, 2'b00, 5'b11000, 32'h7F800000, 5'b11101, "R11 or flags");
    dir(0, -1, 32'h80000000, 2'b00, 0, 32'h00400000, 5'b00000, "R4 exact sub");
    dir(0, -1, 32'h80000001, 2'b00, 0, 32'h00400000, 5'b00011, "R10 inexact sub");
    dir(0, -1, 32'hFFFFFFFF, 2'b00, 0, 32'h00800000, 5'b00001, "R10 round to normal");
    dir(0, -1, 32'hFFFFFE02, 2'b01, 0, 32'h00800000, 5'b00011, "R10 exactly half way");
    dir(0, -200, 32'h80000000, 2'b00, 0, 32'h00000000, 5'b00011, "R4 deep to zero");
    dir(0, -200, 32'h80000000, 2'b01, 0, 32'h00000001, 5'b00011, "R4 deep up");
    dir(1, -31, 32'h80000000, 2'b10, 0, 32'h80000001, 5'b00011, "R4 clamp down");
    dir(0, 0, 32'h80000000, 2'b00, 0, 32'h00800000, 5'b00000, "R3 min normal");

    @(negedge clk);
    check(!out_valid && out_word == 32'h00800000 && out_flags == 0, "R12 hold",
          out_word, out_flags, 32'h00800000, 0);

    for (int n = 0; n < 3000; n++) begin
      bit s; int e; bit [31:0] m; bit [1:0] rm; bit [4:0] fi; bit [31:0] xw; bit [4:0] xf;
      int sh;
      s = 1'($urandom);
      m = $urandom; sh = $urandom_range(0, 32);
      m = (sh == 32) ? 32'h0 : (m >> sh);
      if ($urandom_range(0, 3) == 0) m[7:0] = 8'h80;
      case ($urandom_range(0, 3))
        0: e = int'($urandom_range(0, 600)) - 300;
        1: e = int'($urandom_range(245, 260));
        2: e = int'($urandom_range(0, 40)) - 35;
        default: e = int'($urandom_range(100, 150));
      endcase
      rm = 2'($urandom);
      fi = ($urandom_range(0, 7) == 0) ? 5'($urandom) : 5'b0;
      ref_model(s, e, m, rm, fi, xw, xf);
      apply(s, e, m, rm, fi, xw, xf, "random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual running, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule